// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block puts every device on a downstream two-wire bus back into a known idle state before that bus is handed to a newly selected upstream controller. A start strobe launches a fixed pattern on the downstream clock and data lines. The block never drives a line high: it only asserts open-drain pull-down enables. The pattern is nine clock pulses with data released, so the ninth pulse doubles as a not-acknowledge slot, followed by a STOP condition.

While the pattern runs, a busy flag is high. A one-cycle done pulse marks the end of the pattern. The ownership logic waits for this pulse before it connects the bus to the new controller and raises its interrupt toward the upstream side.

Each half period of the generated bus clock lasts a programmable number of system-clock cycles. A value of zero selects a default that keeps the bus at or below 100 kHz. Values that would exceed 400 kHz are raised to the minimum legal count. When recovery is disabled, a start strobe is answered by an immediate done pulse and the lines are not touched.

Top module: `busrec_seq`

## Requirements
- R1: After reset, `scl_pull_o`, `sda_pull_o`, `busy_o` and `done_o` are all 0.
- R2: A start with `enable_i`=1, accepted while idle, makes `scl_pull_o` go to 1 in the next cycle. The clock line then alternates: nine pull-low phases, each followed by a released phase. This gives exactly nine clock pulses, and the ninth pulse is the not-acknowledge slot.
- R3: `sda_pull_o` stays 0 (data released) for all eighteen phases of the pulse train.
- R4: After the ninth released-clock phase, three more phases follow. First, the clock is pulled low with data still released. Second, data is pulled low while the clock stays low. Third, the clock is released while data stays low. At the end of the third phase, data is released (`sda_pull_o` 1→0 with `scl_pull_o`=0), which forms the STOP condition.
- R5: Every phase lasts exactly H system cycles. H is the effective half period taken from `half_period_i` in the cycle the start was accepted, so `busy_o` is high for exactly 21·H cycles.
- R6: `busy_o` is 1 from the cycle after an enabled start until the sequence ends. Both pull enables are 0 whenever `busy_o` is 0.
- R7: `done_o` is 1 for exactly one cycle: the cycle right after the last STOP phase. In that cycle `busy_o`, `scl_pull_o` and `sda_pull_o` are all 0.
- R8: A start with `enable_i`=0, accepted while idle, gives `done_o`=1 in the next cycle. `busy_o` and both pull enables stay 0.
- R9: While `busy_o` is 1, `start_i` and any change on `enable_i` or `half_period_i` are ignored. The running pattern and its length do not change, and no extra done pulse appears.
- R10: If `half_period_i` is nonzero and below MIN_HALF = ceil(CLK_HZ / 800000), then H = MIN_HALF, which holds the bus at or below 400 kHz.
- R11: If `half_period_i` is 0, then H = DEF_HALF = ceil(CLK_HZ / 200000), which holds the bus at or below 100 kHz. Any other legal value is used as given.
- R12: A start presented in the cycle where `done_o` is 1 is accepted, and `busy_o` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a recovery run |
| enable_i | input | 1 | 1: run the pattern; 0: answer with done only |
| half_period_i | input | CNT_W | Half bus-clock period in system cycles (0 selects the default) |
| scl_pull_o | output | 1 | Pull-down enable for the downstream clock line |
| sda_pull_o | output | 1 | Pull-down enable for the downstream data line |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can coincide in one cycle: the completion pulse of one run and the acceptance of the next start. The bench waits until it sees `done_o`, then raises `start_i` in that same cycle with a different half period. It expects `busy_o` in the following cycle and a full new pattern timed with the new H. A start that arrives mid-run, together with a toggled enable, is judged by the unchanged run length and by the absence of a stray done pulse.

// File: rtl/busrec_pkg.sv
package busrec_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;

  // Phase layout: 2*pulses clock phases, then low gap, data low, clock release
  function automatic int unsigned last_phase(input int unsigned pulses);
    return 2 * pulses + 2;
  endfunction
endpackage

// File: rtl/busrec_ctrl.sv
module busrec_ctrl
  import busrec_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DEF_HALF = 40,
  parameter int unsigned MIN_HALF = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic             seq_end_i,
  output logic             run_o,
  output logic             run_nxt_o,
  output logic             launch_o,
  output logic [CNT_W-1:0] half_q_o,
  output logic             done_o
);
  run_state_t       state_q, state_d;
  logic [CNT_W-1:0] half_q, half_eff;
  logic             done_q, skip;

  always_comb begin
    if (half_i == '0)
      half_eff = CNT_W'(DEF_HALF);
    else if (half_i < CNT_W'(MIN_HALF))
      half_eff = CNT_W'(MIN_HALF);
    else
      half_eff = half_i;
  end

  assign launch_o = (state_q == ST_IDLE) && start_i && enable_i;
  assign skip     = (state_q == ST_IDLE) && start_i && !enable_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch_o) state_d = ST_RUN;
      ST_RUN:  if (seq_end_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      half_q  <= CNT_W'(DEF_HALF);
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch_o) half_q <= half_eff;
      done_q  <= skip || seq_end_i;
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign run_nxt_o = (state_d == ST_RUN);
  assign half_q_o  = half_q;
  assign done_o    = done_q;
endmodule

// File: rtl/busrec_tick.sv
module busrec_tick #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             launch_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             tick_end_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_end_o = run_i && (cnt_q == half_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (launch_i || !run_i || tick_end_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/busrec_phase.sv
module busrec_phase #(
  parameter int unsigned PH_W = 5,
  parameter int unsigned LAST = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch_i,
  input  logic            tick_end_i,
  output logic [PH_W-1:0] ph_nxt_o,
  output logic            seq_end_o
);
  logic [PH_W-1:0] ph_q, ph_d;

  assign seq_end_o = tick_end_i && (ph_q == PH_W'(LAST));

  always_comb begin
    ph_d = ph_q;
    if (launch_i)
      ph_d = '0;
    else if (tick_end_i)
      ph_d = (ph_q == PH_W'(LAST)) ? '0 : ph_q + PH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_d;
  end

  assign ph_nxt_o = ph_d;
endmodule

// File: rtl/busrec_drive.sv
module busrec_drive #(
  parameter int unsigned PH_W   = 5,
  parameter int unsigned PULSES = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_nxt_i,
  input  logic [PH_W-1:0] ph_nxt_i,
  output logic            scl_pull_o,
  output logic            sda_pull_o,
  output logic            busy_o
);
  localparam int unsigned GAP_PH = 2 * PULSES;
  localparam int unsigned SDA_PH = GAP_PH + 1;
  localparam int unsigned REL_PH = GAP_PH + 2;

  logic scl_d, sda_d;

  always_comb begin
    if (ph_nxt_i < PH_W'(GAP_PH))
      scl_d = run_nxt_i && !ph_nxt_i[0];
    else
      scl_d = run_nxt_i && (ph_nxt_i != PH_W'(REL_PH));
    sda_d = run_nxt_i && ((ph_nxt_i == PH_W'(SDA_PH)) || (ph_nxt_i == PH_W'(REL_PH)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pull_o <= 1'b0;
      sda_pull_o <= 1'b0;
      busy_o     <= 1'b0;
    end else begin
      scl_pull_o <= scl_d;
      sda_pull_o <= sda_d;
      busy_o     <= run_nxt_i;
    end
  end
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned BUS_MAX_HZ = 400_000,
  parameter int unsigned BUS_DEF_HZ = 100_000,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PULSES     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] half_period_i,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned MIN_HALF = (CLK_HZ + 2 * BUS_MAX_HZ - 1) / (2 * BUS_MAX_HZ);
  localparam int unsigned DEF_HALF = (CLK_HZ + 2 * BUS_DEF_HZ - 1) / (2 * BUS_DEF_HZ);
  localparam int unsigned LAST     = busrec_pkg::last_phase(PULSES);
  localparam int unsigned PH_W     = $clog2(LAST + 1);

  logic             run, run_nxt, launch, tick_end, seq_end;
  logic [CNT_W-1:0] half_q;
  logic [PH_W-1:0]  ph_nxt;

  busrec_ctrl #(.CNT_W(CNT_W), .DEF_HALF(DEF_HALF), .MIN_HALF(MIN_HALF)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .enable_i(enable_i),
    .half_i(half_period_i), .seq_end_i(seq_end), .run_o(run),
    .run_nxt_o(run_nxt), .launch_o(launch), .half_q_o(half_q), .done_o(done_o)
  );

  busrec_tick #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .run_i(run), .launch_i(launch),
    .half_i(half_q), .tick_end_o(tick_end)
  );

  busrec_phase #(.PH_W(PH_W), .LAST(LAST)) u_phase (
    .clk(clk), .rst(rst), .launch_i(launch), .tick_end_i(tick_end),
    .ph_nxt_o(ph_nxt), .seq_end_o(seq_end)
  );

  busrec_drive #(.PH_W(PH_W), .PULSES(PULSES)) u_drive (
    .clk(clk), .rst(rst), .run_nxt_i(run_nxt), .ph_nxt_i(ph_nxt),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .busy_o(busy_o)
  );
endmodule

// File: rtl/busrec_seq_chk.sv
module busrec_seq_chk #(
  parameter int unsigned PULSES = 9
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic enable_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic busy_o,
  input logic done_o
);
  logic       scl_prev;
  logic [7:0] fall_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b0;
      fall_cnt <= '0;
    end else begin
      scl_prev <= scl_pull_o;
      if (done_o)                      fall_cnt <= '0;
      else if (scl_pull_o && !scl_prev) fall_cnt <= fall_cnt + 8'd1;
    end
  end

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!scl_pull_o && !sda_pull_o));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_sda_low_clock_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> scl_pull_o);

  p_stop_release_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull_o) |-> (done_o && !scl_pull_o));

  p_disabled_done_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && !enable_i) |=> (done_o && !busy_o && !scl_pull_o));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_pulse_count_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((fall_cnt == 8'd0) || (fall_cnt == 8'(PULSES + 1))));
endmodule

bind busrec_seq busrec_seq_chk #(.PULSES(PULSES)) u_chk (.*);

// File: tb/busrec_seq_tb_top.sv
module busrec_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8_000_000;
  localparam int CNT_W      = 16;
  localparam int MIN_H      = 10;
  localparam int DEF_H      = 40;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             enable_i = 1'b0;
  logic [CNT_W-1:0] half_period_i = '0;
  logic             scl_pull_o, sda_pull_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busrec_seq #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .enable_i(enable_i),
    .half_period_i(half_period_i), .scl_pull_o(scl_pull_o),
    .sda_pull_o(sda_pull_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_half(input int h);
    if (h == 0) return DEF_H;
    if (h < MIN_H) return MIN_H;
    return h;
  endfunction

  // Behavioural reference: time since launch
  int m_t = -1;
  int m_h = 1;
  bit m_done = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_t = -1;
      m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_t < 0) begin
        if (start_i) begin
          if (enable_i) begin
            m_t = 0;
            m_h = eff_half(int'(half_period_i));
          end else begin
            m_done = 1'b1;
          end
        end
      end else begin
        m_t++;
        if (m_t == 21 * m_h) begin
          m_t = -1;
          m_done = 1'b1;
        end
      end
    end
  end

  int exp_len_q[$];
  int run_len = 0;
  int falls = 0;
  bit scl_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit e_busy = (m_t >= 0);
      automatic int ph = e_busy ? (m_t / m_h) : 0;
      automatic bit e_scl = e_busy && ((ph < 18) ? (ph % 2 == 0) : (ph != 20));
      automatic bit e_sda = e_busy && ((ph == 19) || (ph == 20));
      chk(scl_pull_o == e_scl, "R2 clock pattern", scl_pull_o, e_scl);
      chk(sda_pull_o == e_sda, (ph < 18) ? "R3 data released" : "R4 stop pattern",
          sda_pull_o, e_sda);
      chk(busy_o == e_busy, "R6 busy", busy_o, e_busy);
      chk(done_o == m_done, "R7 done pulse", done_o, m_done);
      if (busy_o) run_len++;
      if (scl_pull_o && !scl_prev) falls++;
      if (done_o && run_len > 0) begin
        automatic int exp_h = (exp_len_q.size() > 0) ? exp_len_q.pop_front() : 0;
        chk(run_len == 21 * exp_h, "R5 run length", run_len, 21 * exp_h);
        chk(falls == 10, "R2 pulse count", falls, 10);
        run_len = 0;
        falls = 0;
      end
      scl_prev = scl_pull_o;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic launch(input int half, input bit en);
    @(negedge clk);
    start_i = 1'b1;
    enable_i = en;
    half_period_i = CNT_W'(half);
    if (en) exp_len_q.push_back(eff_half(half));
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_pull_o && !sda_pull_o && !busy_o && !done_o, "R1 reset state",
        {scl_pull_o, sda_pull_o, busy_o, done_o}, 0);
    rst = 1'b0;

    // plain run, legal half period
    launch(12, 1'b1);
    wait_done();

    // R10: too fast request is clamped
    launch(3, 1'b1);
    wait_done();

    // R11: zero selects the default
    launch(0, 1'b1);
    wait_done();

    // R8: disabled start
    @(negedge clk);
    start_i = 1'b1; enable_i = 1'b0; half_period_i = CNT_W'(20);
    @(negedge clk);
    chk(done_o && !busy_o && !scl_pull_o && !sda_pull_o, "R8 disabled done",
        {done_o, busy_o, scl_pull_o, sda_pull_o}, 8);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!scl_pull_o && !busy_o, "R8 no line activity", scl_pull_o, 0);

    // R9: start and input changes mid-run
    launch(15, 1'b1);
    repeat (30) @(negedge clk);
    start_i = 1'b1; enable_i = 1'b0; half_period_i = CNT_W'(50);
    repeat (3) @(negedge clk);
    chk(busy_o && !done_o, "R9 start ignored", {busy_o, done_o}, 2);
    start_i = 1'b0; enable_i = 1'b1;
    wait_done();

    // R12: new start in the done cycle
    start_i = 1'b1; enable_i = 1'b1; half_period_i = CNT_W'(11);
    exp_len_q.push_back(11);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R12 back-to-back start", busy_o, 1);
    wait_done();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule